// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two page table entries from memory, one after the other. The virtual address is cut into a 10-bit index into the top-level table (bits 31:22), a 10-bit index into a second-level table (bits 21:12) and a 12-bit byte offset within a 4 KB page (bits 11:0). A base register holds the byte address of the top-level table. The top-level entry names the page of the second-level table. The second-level entry names the physical frame.

Each memory read goes out through a request/acknowledge port, and the walker waits as many cycles as the memory needs. At both levels it checks the entry's valid flag, and for a write it also checks the writable flag. It ends every walk with a one-cycle completion pulse that carries either the physical address or a fault code. A fault found in the top-level entry ends the walk without a second read.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req` and `done` are 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1. While a walk is in progress, `req_ready` is 0, and any `req_valid`, `req_vaddr` or `req_write` presented then has no effect on the result of that walk.
- R3: The first read goes to address `table_base + 4 * vaddr[31:22]`. Here `table_base` is the value last loaded through `tbl_base_load`/`tbl_base_value`, and a load affects every walk accepted after it.
- R4: An entry is 32 bits: a page number in bits 31:12, reserved bits 11:2, the writable flag in bit 1 and the valid flag in bit 0. When the top-level entry passes its checks, the second read goes to `{entry[31:12], 12'h000} + 4 * vaddr[21:12]`.
- R5: When the second-level entry passes its checks, `done_paddr` equals `{entry[31:12], vaddr[11:0]}` and `done_fault` is 0 (no fault).
- R6: If the top-level entry has its valid flag clear or a reserved bit set, the walk ends with `done_fault` = 1 and no second read is issued.
- R7: If the second-level entry has its valid flag clear or a reserved bit set, the walk ends with `done_fault` = 2.
- R8: When `req_write` is 1 and a valid entry at either level has its writable flag clear, the walk ends with `done_fault` = 3. A fault at the top level skips the second read. An invalid entry reports its invalid code rather than 3. A read request never faults on the writable flag.
- R9: `done` is high for exactly one cycle per walk, and `req_ready` is 1 in the cycle after it. When `done_fault` is not 0, `done_paddr` is 0.
- R10: `mem_req` stays high with a stable `mem_addr` until the cycle in which `mem_ack` is seen, and every `mem_addr` it presents is 4-byte aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base_load | input | 1 | Loads a new top-level table address |
| tbl_base_value | input | 32 | Byte address of the top-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_ack | input | 1 | Memory read data is valid this cycle |
| mem_rdata | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 32 | Physical address, or 0 on a fault |
| done_fault | output | 2 | 0 none, 1 top-level invalid, 2 second-level invalid, 3 write to read-only |

## Verification
The hardest case to reach is a write that is refused at the top level while the same second-level index would have been legal. The bench proves this case by recording every memory address that is acknowledged, so it can show that the second read never went out. To get there, the bench sweeps eight top-level slots and eight second-level slots whose flag patterns cycle through all four valid/writable combinations, tries both access types, and varies the memory latency from zero to two wait cycles. Requests presented during a long walk and a change of table base are driven as separate scenarios.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_OUTER = 2'd1,
    WS_INNER = 2'd2,
    WS_DONE  = 2'd3
  } walk_state_t;

  typedef enum logic [1:0] {
    FLT_NONE          = 2'd0,
    FLT_OUTER_INVALID = 2'd1,
    FLT_INNER_INVALID = 2'd2,
    FLT_WRITE_PROT    = 2'd3
  } fault_t;

  localparam int PTE_VALID_BIT  = 0;
  localparam int PTE_WRITE_BIT  = 1;
  localparam int PTE_FLAG_BITS  = 2;
  localparam int PTE_SIZE_LOG2  = 2;

endpackage

// File: rtl/pt_addr_split.sv
module pt_addr_split #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] vaddr,
  output logic [IDX_W-1:0]  outer_idx,
  output logic [IDX_W-1:0]  inner_idx,
  output logic [OFF_W-1:0]  offset
);

  function automatic logic [IDX_W-1:0] top_index(input logic [ADDR_W-1:0] va);
    return va[ADDR_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] mid_index(input logic [ADDR_W-1:0] va);
    return va[OFF_W +: IDX_W];
  endfunction

  always_comb begin
    outer_idx = top_index(vaddr);
    inner_idx = mid_index(vaddr);
    offset    = vaddr[OFF_W-1:0];
  end

endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
  import pt_walker_pkg::*;
#(
  parameter int ENTRY_W = 32,
  parameter int OFF_W   = 12
) (
  input  logic [ENTRY_W-1:0]       entry,
  input  logic                     is_write,
  output logic [ENTRY_W-OFF_W-1:0] page_base,
  output logic                     bad_entry,
  output logic                     write_denied,
  output logic                     entry_ok
);

  localparam int RSV_W = OFF_W - PTE_FLAG_BITS;

  function automatic logic entry_usable(input logic [ENTRY_W-1:0] e);
    return e[PTE_VALID_BIT] && (e[OFF_W-1:PTE_FLAG_BITS] == {RSV_W{1'b0}});
  endfunction

  function automatic logic write_blocked(input logic [ENTRY_W-1:0] e, input logic wr);
    return wr && !e[PTE_WRITE_BIT];
  endfunction

  always_comb begin
    page_base    = entry[ENTRY_W-1:OFF_W];
    bad_entry    = !entry_usable(entry);
    write_denied = entry_usable(entry) && write_blocked(entry, is_write);
    entry_ok     = entry_usable(entry) && !write_blocked(entry, is_write);
  end

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_ack,
  input  logic        entry_ok,
  output walk_state_t state,
  output logic        accept,
  output logic        outer_pass,
  output logic        outer_fail,
  output logic        inner_ack,
  output logic        req_ready,
  output logic        mem_req,
  output logic        done
);

  walk_state_t state_q, state_d;

  always_comb begin
    accept     = (state_q == WS_IDLE) && req_valid;
    outer_pass = (state_q == WS_OUTER) && mem_ack && entry_ok;
    outer_fail = (state_q == WS_OUTER) && mem_ack && !entry_ok;
    inner_ack  = (state_q == WS_INNER) && mem_ack;
    state_d    = state_q;
    unique case (state_q)
      WS_IDLE:  if (accept) state_d = WS_OUTER;
      WS_OUTER: if (outer_pass) state_d = WS_INNER;
                else if (outer_fail) state_d = WS_DONE;
      WS_INNER: if (inner_ack) state_d = WS_DONE;
      WS_DONE:  state_d = WS_IDLE;
      default:  state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= WS_IDLE;
    else        state_q <= state_d;
  end

  assign state     = state_q;
  assign req_ready = (state_q == WS_IDLE);
  assign mem_req   = (state_q == WS_OUTER) || (state_q == WS_INNER);
  assign done      = (state_q == WS_DONE);

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_req, done}) && (req_ready || mem_req || done)); // R2

  AST_OUTER_FAIL_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
    outer_fail |=> done && !mem_req); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready); // R9

  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R2

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_base_load,
  input  logic [ADDR_W-1:0] tbl_base_value,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] done_paddr,
  output logic [1:0]        done_fault
);

  localparam int BASE_W = ADDR_W - OFF_W;

  walk_state_t       state;
  logic              accept, outer_pass, outer_fail, inner_ack;
  logic [ADDR_W-1:0] tbl_base_q;
  logic [ADDR_W-1:0] vaddr_q;
  logic              write_q;
  logic [BASE_W-1:0] inner_tbl_q;
  logic [ADDR_W-1:0] paddr_q;
  fault_t            fault_q;

  logic [IDX_W-1:0]  outer_idx, inner_idx;
  logic [OFF_W-1:0]  page_off;
  logic [BASE_W-1:0] entry_base;
  logic              bad_entry, write_denied, entry_ok;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] tbl,
                                                  input logic [IDX_W-1:0]  idx);
    return tbl + (ADDR_W'(idx) << PTE_SIZE_LOG2);
  endfunction

  function automatic logic [ADDR_W-1:0] page_addr(input logic [BASE_W-1:0] pg);
    return {pg, {OFF_W{1'b0}}};
  endfunction

  function automatic fault_t fault_for(input logic at_inner, input logic denied);
    if (denied)   return FLT_WRITE_PROT;
    if (at_inner) return FLT_INNER_INVALID;
    return FLT_OUTER_INVALID;
  endfunction

  pt_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
    .vaddr     (vaddr_q),
    .outer_idx (outer_idx),
    .inner_idx (inner_idx),
    .offset    (page_off)
  );

  pt_entry_eval #(.ENTRY_W(ADDR_W), .OFF_W(OFF_W)) u_eval (
    .entry        (mem_rdata),
    .is_write     (write_q),
    .page_base    (entry_base),
    .bad_entry    (bad_entry),
    .write_denied (write_denied),
    .entry_ok     (entry_ok)
  );

  pt_walk_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .mem_ack    (mem_ack),
    .entry_ok   (entry_ok),
    .state      (state),
    .accept     (accept),
    .outer_pass (outer_pass),
    .outer_fail (outer_fail),
    .inner_ack  (inner_ack),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .done       (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_base_q <= '0;
    end else if (tbl_base_load) begin
      tbl_base_q <= tbl_base_value;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaddr_q     <= '0;
      write_q     <= 1'b0;
      inner_tbl_q <= '0;
      paddr_q     <= '0;
      fault_q     <= FLT_NONE;
    end else begin
      if (accept) begin
        vaddr_q <= req_vaddr;
        write_q <= req_write;
      end
      if (outer_pass) begin
        inner_tbl_q <= entry_base;
      end
      if (outer_fail) begin
        paddr_q <= '0;
        fault_q <= fault_for(1'b0, write_denied);
      end
      if (inner_ack) begin
        if (entry_ok) begin
          paddr_q <= {entry_base, page_off};
          fault_q <= FLT_NONE;
        end else begin
          paddr_q <= '0;
          fault_q <= fault_for(1'b1, write_denied);
        end
      end
    end
  end

  always_comb begin
    unique case (state)
      WS_OUTER: mem_addr = slot_addr(tbl_base_q, outer_idx);
      WS_INNER: mem_addr = slot_addr(page_addr(inner_tbl_q), inner_idx);
      default:  mem_addr = '0;
    endcase
  end

  assign done_paddr = paddr_q;
  assign done_fault = fault_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr)); // R10

  AST_INNER_FOLLOWS_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
    outer_pass |=> mem_req && (mem_addr[OFF_W +: BASE_W] >= inner_tbl_q)); // R4

  AST_FAULT_ZERO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault != 2'd0) |-> done_paddr == '0); // R9

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault == 2'd0) |-> done_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]); // R5

  AST_VADDR_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || done) |=> $stable(vaddr_q) && $stable(write_q)); // R2

endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_base_load;
  logic [31:0] tbl_base_value;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        done;
  logic [31:0] done_paddr;
  logic [1:0]  done_fault;

  always #2.5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n),
    .tbl_base_load(tbl_base_load), .tbl_base_value(tbl_base_value),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .done_paddr(done_paddr), .done_fault(done_fault)
  );

  logic [31:0] mem [logic [31:0]];
  int          lat = 0;
  int          wcnt = 0;
  logic [31:0] rd_log [4];
  int          rd_n = 0;
  int          checks = 0;
  int          errors = 0;

  localparam logic [31:0] TBL_A = 32'h0010_0000;
  localparam logic [31:0] TBL_B = 32'h0014_0000;

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack   = 1'b1;
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        wcnt      = 0;
      end else begin
        wcnt++;
      end
    end else begin
      wcnt = 0;
    end
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (rd_n < 4) rd_log[rd_n] = mem_addr;
      rd_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int oi_of(input int o);
    return (o * 129) % 1024;
  endfunction
  function automatic int ii_of(input int i);
    return (i * 73 + 5) % 1024;
  endfunction
  function automatic logic [31:0] make_entry(input int pg, input int flags);
    return (32'(pg) << 12) | 32'(flags & 3);
  endfunction

  task automatic walk(input logic [31:0] va, input logic wr,
                      output logic [31:0] pa, output logic [1:0] flt);
    int n;
    @(negedge clk);
    rd_n      = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    pa  = done_paddr;
    flt = done_fault;
    @(negedge clk);
    check(!done && req_ready, "R9 done one cycle then ready", {30'b0, done, req_ready}, 32'h1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pa;
    logic [1:0]  flt;
    rst_n = 1'b0; tbl_base_load = 1'b0; tbl_base_value = '0;
    req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
    mem_ack = 1'b0; mem_rdata = '0;

    for (int o = 0; o < 8; o++) begin
      mem[TBL_A + 32'(4 * oi_of(o))] = make_entry(32'h200 + o, o % 4);
      for (int i = 0; i < 8; i++)
        mem[(32'(32'h200 + o) << 12) + 32'(4 * ii_of(i))] =
          make_entry(32'h30000 + o * 16 + i, (i + o) % 4);
    end
    mem[TBL_A + 32'(4 * 1000)] = make_entry(32'h280, 3) | 32'h10;
    mem[TBL_A + 32'(4 * 1001)] = make_entry(32'h281, 3);
    mem[(32'h281 << 12) + 32'(4 * 7)] = make_entry(32'h12345, 3) | 32'h400;

    repeat (3) @(negedge clk);
    check(req_ready && !mem_req && !done, "R1 reset outputs",
          {29'b0, req_ready, mem_req, done}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !mem_req && !done, "R1 idle after reset",
          {29'b0, req_ready, mem_req, done}, 32'h4);
    tbl_base_load = 1'b1; tbl_base_value = TBL_A;
    @(negedge clk);
    tbl_base_load = 1'b0;

    for (int o = 0; o < 8; o++) begin
      for (int i = 0; i < 8; i++) begin
        for (int w = 0; w < 2; w++) begin
          int fo, fi, off, exp_reads;
          logic [31:0] va, exp_pa;
          logic [1:0]  exp_f;
          fo  = o % 4;
          fi  = (i + o) % 4;
          off = (o * 37 + i * 91 + w * 5) & 12'hFFF;
          va  = (32'(oi_of(o)) << 22) | (32'(ii_of(i)) << 12) | 32'(off);
          lat = (o + i + w) % 3;
          exp_pa = 32'h0;
          if ((fo & 1) == 0)                  begin exp_f = 2'd1; exp_reads = 1; end
          else if (w == 1 && (fo & 2) == 0)   begin exp_f = 2'd3; exp_reads = 1; end
          else if ((fi & 1) == 0)             begin exp_f = 2'd2; exp_reads = 2; end
          else if (w == 1 && (fi & 2) == 0)   begin exp_f = 2'd3; exp_reads = 2; end
          else begin
            exp_f = 2'd0; exp_reads = 2;
            exp_pa = (32'(32'h30000 + o * 16 + i) << 12) | 32'(off);
          end
          walk(va, w[0], pa, flt);
          check(flt == exp_f, exp_f == 2'd1 ? "R6 outer invalid code" :
                exp_f == 2'd2 ? "R7 inner invalid code" :
                exp_f == 2'd3 ? "R8 write protect code" : "R5 no fault code",
                32'(flt), 32'(exp_f));
          check(pa == exp_pa, exp_f == 2'd0 ? "R5 physical address" : "R9 paddr zero on fault",
                pa, exp_pa);
          check(rd_n == exp_reads, exp_reads == 1 ? "R6 R8 inner read skipped" : "R4 two reads",
                32'(rd_n), 32'(exp_reads));
          check(rd_log[0] == TBL_A + 32'(4 * oi_of(o)), "R3 outer entry address",
                rd_log[0], TBL_A + 32'(4 * oi_of(o)));
          if (exp_reads == 2 && rd_n == 2)
            check(rd_log[1] == (32'(32'h200 + o) << 12) + 32'(4 * ii_of(i)),
                  "R4 inner entry address", rd_log[1],
                  (32'(32'h200 + o) << 12) + 32'(4 * ii_of(i)));
        end
      end
    end

    // R6: reserved bit set in outer entry counts as invalid
    lat = 1;
    walk((32'd1000 << 22) | 32'h0000_0ABC, 1'b0, pa, flt);
    check(flt == 2'd1 && rd_n == 1, "R6 reserved bit outer", {30'b0, flt}, 32'h1);
    // R7: reserved bit set in inner entry counts as invalid
    walk((32'd1001 << 22) | (32'd7 << 12) | 32'h0000_0123, 1'b0, pa, flt);
    check(flt == 2'd2 && rd_n == 2, "R7 reserved bit inner", {30'b0, flt}, 32'h2);

    // R2: requests during a walk are ignored
    lat = 2;
    @(negedge clk);
    rd_n = 0;
    req_valid = 1'b1; req_write = 1'b0;
    req_vaddr = (32'(oi_of(3)) << 22) | (32'(ii_of(0)) << 12) | 32'h55;
    @(negedge clk);
    check(!req_ready, "R2 busy after accept", {31'b0, req_ready}, 32'h0);
    req_write = 1'b1;
    req_vaddr = (32'(oi_of(0)) << 22) | 32'hFFF;
    repeat (3) @(negedge clk);
    check(!req_ready, "R2 ready low mid walk", {31'b0, req_ready}, 32'h0);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    check(done_fault == 2'd0 && done_paddr == ((32'(32'h30000 + 48) << 12) | 32'h55),
          "R2 result from first request", done_paddr, (32'(32'h30000 + 48) << 12) | 32'h55);
    @(negedge clk);

    // R3: new table base applies to the next walk
    mem[TBL_B + 32'(4 * 9)] = make_entry(32'h250, 3);
    mem[(32'h250 << 12) + 32'(4 * 2)] = make_entry(32'h7ABCD, 1);
    @(negedge clk);
    tbl_base_load = 1'b1; tbl_base_value = TBL_B;
    @(negedge clk);
    tbl_base_load = 1'b0;
    lat = 0;
    walk((32'd9 << 22) | (32'd2 << 12) | 32'h321, 1'b0, pa, flt);
    check(rd_log[0] == TBL_B + 32'd36, "R3 reloaded table base", rd_log[0], TBL_B + 32'd36);
    check(pa == 32'h7ABC_D321 && flt == 2'd0, "R5 read of read-only page", pa, 32'h7ABC_D321);
    walk((32'd9 << 22) | (32'd2 << 12) | 32'h321, 1'b1, pa, flt);
    check(flt == 2'd3 && rd_n == 2, "R8 write to read-only leaf", {30'b0, flt}, 32'h3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule